// File: doc/BRIEF.md
# Colour Channel Sequencer for a Sensor Front End

This block decides, for every pixel conversion of a scanning front end, which of the three analog inputs feeds the sampler and which colour's gain/offset register set is applied. It follows a line-sync level and a per-conversion step strobe, and it walks one of several colour patterns. The patterns are: one colour per line rotating over three lines, three colours interleaved on one input, single-colour monochrome on any input, a two-line 2x2 mosaic, and a two-line four-pixel stripe pattern whose second line reverses the red/blue positions.

A line begins on the first rising clock edge at which the line-sync input is seen low after having been high. On that edge the mode field is captured for the whole line, the line counter moves to the next line of the pattern, and the pixel position returns to zero. A pulse on the mode-write input arms a restart, so the next line to begin is the first line of the pattern. The input select can change only at a line start. The colour index moves on by one position for each accepted step strobe.

Control is a three-state machine: `ST_IDLE` (after reset, before any line sync has been seen), `ST_BLANK` (line sync high, no line active) and `ST_ACTIVE` (inside a line). It has three transitions. IDLE goes to BLANK when line sync is high. BLANK goes to ACTIVE when line sync is low; this is the line-start edge. ACTIVE goes back to BLANK when line sync rises.

Top module: `chan_seq`

## Requirements
- R1: After reset, and until the first line starts, `in_sel` and `color_sel` are both 0 (red). Encoding for both outputs: 0 = red, 1 = green, 2 = blue.
- R2: Mode 0 (line rotation) sets input and colour to red, green, blue on successive lines, repeating. Within a line, neither output changes however many steps arrive.
- R3: Mode 1 (interleaved) fixes the input at blue. The colour goes red, green, blue, red... with one step per accepted strobe, starting at red on each line.
- R4: Modes 3, 4 and 5 fix input and colour to red, green and blue respectively. The reserved mode 2 behaves exactly like mode 3.
- R5: Mode 6 (mosaic) fixes the input at blue. The colour repeats green, red on the first line of the pattern and blue, green on the second line, and the two lines alternate.
- R6: Mode 7 (stripe) fixes the input at blue. The colour repeats red, green, blue, green on the first line and blue, green, red, green on the second line, and the two lines alternate.
- R7: On the line-start edge the outputs take the first colour of the new line. A step strobe present on that same edge is ignored.
- R8: While line sync is high, step strobes and mode writes leave both outputs unchanged.
- R9: A mode-write pulse makes the next line start use the first line of the pattern. This also holds when the pulse falls on the line-start edge itself.
- R10: The mode field is sampled only on the line-start edge. A change in the middle of a line has no effect until the next line starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_sync | input | 1 | High during line blanking; the high-to-low change starts a line |
| conv_done | input | 1 | One-cycle strobe per finished conversion |
| mode_code | input | 3 | Colour pattern selection |
| mode_written | input | 1 | Pulse when the mode register has been written |
| in_sel | output | 2 | Analog input select (0 red, 1 green, 2 blue) |
| color_sel | output | 2 | Gain/offset set index (0 red, 1 green, 2 blue) |

## Verification
The hardest situations to reach are those where two events fall on the line-start edge: a step strobe held high across the fall of line sync, and a mode-write pulse landing exactly on that edge. Without care, the first could skip the line's first colour and the second could be lost. The stimulus holds the strobe high through the last blanking cycle and the first line cycle, and it times a write to coincide with the cycle in which line sync drops. A second hard case is the mid-line mode change: the bench writes a new pattern inside a line and then checks that both the input select and the colour sequence keep the old pattern until the next line starts.

// File: rtl/chan_seq_pkg.sv
package chan_seq_pkg;

    localparam int unsigned IDX_W = 2;
    localparam int unsigned PER_W = IDX_W + 1;

    typedef enum logic [1:0] {
        CH_RED   = 2'd0,
        CH_GREEN = 2'd1,
        CH_BLUE  = 2'd2
    } chan_e;

    typedef enum logic [2:0] {
        MD_LINE   = 3'd0,
        MD_PIXEL  = 3'd1,
        MD_RSVD   = 3'd2,
        MD_MONO_R = 3'd3,
        MD_MONO_G = 3'd4,
        MD_MONO_B = 3'd5,
        MD_MOSAIC = 3'd6,
        MD_STRIPE = 3'd7
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BLANK  = 2'd1,
        ST_ACTIVE = 2'd2
    } seq_state_e;

    // number of distinct lines before a pattern repeats
    function automatic logic [PER_W-1:0] line_period(input mode_e m);
        logic [PER_W-1:0] p;
        unique case (m)
            MD_LINE:              p = PER_W'(3);
            MD_MOSAIC, MD_STRIPE: p = PER_W'(2);
            default:              p = PER_W'(1);
        endcase
        return p;
    endfunction

    // number of pixel positions before the colour order repeats
    function automatic logic [PER_W-1:0] pixel_period(input mode_e m);
        logic [PER_W-1:0] p;
        unique case (m)
            MD_PIXEL:  p = PER_W'(3);
            MD_MOSAIC: p = PER_W'(2);
            MD_STRIPE: p = PER_W'(4);
            default:   p = PER_W'(1);
        endcase
        return p;
    endfunction

endpackage

// File: rtl/line_tracker.sv
module line_tracker
    import chan_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_load,
    input  logic             mode_wr,
    input  mode_e            mode_in,
    output logic [IDX_W-1:0] line_idx,
    output mode_e            line_mode
);

    logic             pend_q;
    logic [IDX_W-1:0] line_q;
    mode_e            mode_q;
    logic             restart_eff;
    logic [PER_W-1:0] lp;
    logic [PER_W-1:0] line_inc;
    logic [IDX_W-1:0] line_next;

    always_comb begin
        restart_eff = pend_q | mode_wr;
        lp          = line_period(mode_in);
        line_inc    = {1'b0, line_q} + PER_W'(1);
        if (restart_eff || (line_inc >= lp)) begin
            line_next = '0;
        end else begin
            line_next = line_inc[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b1;
            line_q <= '0;
            mode_q <= MD_LINE;
        end else if (line_load) begin
            pend_q <= 1'b0;
            line_q <= line_next;
            mode_q <= mode_in;
        end else begin
            pend_q <= restart_eff;
        end
    end

    assign line_idx  = line_q;
    assign line_mode = mode_q;

    // R9: an armed or coincident restart puts the pattern on its first line
    assert_restart_line0_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (line_load && (pend_q || mode_wr)) |=> (line_q == '0));

endmodule

// File: rtl/pixel_phase.sv
module pixel_phase
    import chan_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_load,
    input  logic             step,
    input  mode_e            line_mode,
    output logic [IDX_W-1:0] pix_idx
);

    logic [IDX_W-1:0] pix_q;
    logic [PER_W-1:0] pp;
    logic [PER_W-1:0] pix_inc;

    always_comb begin
        pp      = pixel_period(line_mode);
        pix_inc = {1'b0, pix_q} + PER_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_q <= '0;
        end else if (line_load) begin
            pix_q <= '0;
        end else if (step) begin
            pix_q <= (pix_inc >= pp) ? '0 : pix_inc[IDX_W-1:0];
        end
    end

    assign pix_idx = pix_q;

    // R7: each line begins at pixel position zero
    assert_line_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        line_load |=> (pix_q == '0));

    // R3: the position stays inside the current pattern length
    assert_phase_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, pix_q} < pixel_period(line_mode)));

endmodule

// File: rtl/color_lookup.sv
module color_lookup
    import chan_seq_pkg::*;
(
    input  mode_e            line_mode,
    input  logic [IDX_W-1:0] line_idx,
    input  logic [IDX_W-1:0] pix_idx,
    output chan_e            in_ch,
    output chan_e            color_ch
);

    always_comb begin
        in_ch    = CH_BLUE;
        color_ch = CH_RED;
        unique case (line_mode)
            MD_LINE: begin
                in_ch    = chan_e'(line_idx);
                color_ch = chan_e'(line_idx);
            end
            MD_PIXEL: begin
                in_ch    = CH_BLUE;
                color_ch = chan_e'(pix_idx);
            end
            MD_RSVD, MD_MONO_R: begin
                in_ch    = CH_RED;
                color_ch = CH_RED;
            end
            MD_MONO_G: begin
                in_ch    = CH_GREEN;
                color_ch = CH_GREEN;
            end
            MD_MONO_B: begin
                in_ch    = CH_BLUE;
                color_ch = CH_BLUE;
            end
            MD_MOSAIC: begin
                in_ch = CH_BLUE;
                if (pix_idx[0]) color_ch = line_idx[0] ? CH_GREEN : CH_RED;
                else            color_ch = line_idx[0] ? CH_BLUE  : CH_GREEN;
            end
            MD_STRIPE: begin
                in_ch = CH_BLUE;
                if (pix_idx[0])                color_ch = CH_GREEN;
                else if (pix_idx[1] == line_idx[0]) color_ch = CH_RED;
                else                           color_ch = CH_BLUE;
            end
        endcase
    end

endmodule

// File: rtl/chan_seq.sv
module chan_seq
    import chan_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_sync,
    input  logic       conv_done,
    input  logic [2:0] mode_code,
    input  logic       mode_written,
    output logic [1:0] in_sel,
    output logic [1:0] color_sel
);

    seq_state_e       state_q, state_d;
    logic             line_load;
    logic             step;
    logic [IDX_W-1:0] line_idx;
    logic [IDX_W-1:0] pix_idx;
    mode_e            line_mode;
    chan_e            in_ch;
    chan_e            color_ch;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (line_sync)  state_d = ST_BLANK;
            ST_BLANK:  if (!line_sync) state_d = ST_ACTIVE;
            ST_ACTIVE: if (line_sync)  state_d = ST_BLANK;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // per-state outputs
    always_comb begin
        line_load = 1'b0;
        step      = 1'b0;
        unique case (state_q)
            ST_BLANK:  line_load = !line_sync;
            ST_ACTIVE: step      = !line_sync && conv_done;
            default: begin
                line_load = 1'b0;
                step      = 1'b0;
            end
        endcase
    end

    line_tracker u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_load (line_load),
        .mode_wr   (mode_written),
        .mode_in   (mode_e'(mode_code)),
        .line_idx  (line_idx),
        .line_mode (line_mode)
    );

    pixel_phase u_pix (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_load (line_load),
        .step      (step),
        .line_mode (line_mode),
        .pix_idx   (pix_idx)
    );

    color_lookup u_lut (
        .line_mode (line_mode),
        .line_idx  (line_idx),
        .pix_idx   (pix_idx),
        .in_ch     (in_ch),
        .color_ch  (color_ch)
    );

    assign in_sel    = in_ch;
    assign color_sel = color_ch;

    // R2: the input select moves only when a line starts
    assert_mux_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !line_load |=> $stable(in_sel));

    // R8: nothing moves during blanking
    assert_blank_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        line_sync |=> ($stable(color_sel) && $stable(in_sel)));

    // R1: before the first line the outputs stay at red
    assert_idle_red_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (in_sel == 2'd0 && color_sel == 2'd0));

endmodule

// File: tb/chan_seq_test.sv
module chan_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_sync = 1'b0;
    logic       conv_done = 1'b0;
    logic [2:0] mode_code = 3'd0;
    logic       mode_written = 1'b0;
    logic [1:0] in_sel;
    logic [1:0] color_sel;

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    string cur_req = "R1";

    // reference model state
    int m_state = 0;   // 0 before first line, 1 blanking, 2 in line
    int m_line  = 0;
    int m_pix   = 0;
    int m_mode  = 0;
    bit m_pend  = 1;

    always #2.5 clk = ~clk;

    chan_seq uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_sync    (line_sync),
        .conv_done    (conv_done),
        .mode_code    (mode_code),
        .mode_written (mode_written),
        .in_sel       (in_sel),
        .color_sel    (color_sel)
    );

    function automatic int lines_of(int m);
        if (m == 0) return 3;
        if (m == 6 || m == 7) return 2;
        return 1;
    endfunction

    function automatic int pixels_of(int m);
        if (m == 1) return 3;
        if (m == 6) return 2;
        if (m == 7) return 4;
        return 1;
    endfunction

    function automatic int exp_input(int m, int ln);
        case (m)
            0: return ln;
            2, 3: return 0;
            4: return 1;
            default: return 2;
        endcase
    endfunction

    function automatic int exp_color(int m, int ln, int px);
        int mos [2][2]    = '{'{1, 0}, '{2, 1}};
        int stripe [2][4] = '{'{0, 1, 2, 1}, '{2, 1, 0, 1}};
        case (m)
            0: return ln;
            1: return px;
            2, 3: return 0;
            4: return 1;
            5: return 2;
            6: return mos[ln][px];
            default: return stripe[ln][px];
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst_n) begin
            if (m_state == 1 && !line_sync) begin
                m_line  = (m_pend || mode_written) ? 0 : (m_line + 1) % lines_of(mode_code);
                m_pend  = 0;
                m_mode  = mode_code;
                m_pix   = 0;
                m_state = 2;
            end else begin
                if (mode_written) m_pend = 1;
                if (m_state == 2 && !line_sync && conv_done)
                    m_pix = (m_pix + 1) % pixels_of(m_mode);
                if (line_sync) m_state = 1;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            int ei, ec;
            ei = exp_input(m_mode, m_line);
            ec = exp_color(m_mode, m_line, m_pix);
            total++;
            if (in_sel !== 2'(ei) || color_sel !== 2'(ec)) begin
                bad++;
                $display("FAIL %s: in_sel=%0d color_sel=%0d expected in_sel=%0d color_sel=%0d",
                         cur_req, in_sel, color_sel, ei, ec);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_mode(int code);
        @(negedge clk);
        mode_code    = 3'(code);
        mode_written = 1'b1;
        @(negedge clk);
        mode_written = 1'b0;
    endtask

    task automatic run_line(int nsteps, bit blank_steps);
        @(negedge clk);
        line_sync = 1'b1;
        conv_done = blank_steps;
        tick(2);
        line_sync = 1'b0;
        conv_done = 1'b0;
        tick(1);
        for (int i = 0; i < nsteps; i++) begin
            conv_done = 1'b1;
            tick(1);
            conv_done = 1'b0;
            tick(1);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run state=hung expected=finished");
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(3);
        // R1: reset values
        total++;
        if (in_sel !== 2'd0 || color_sel !== 2'd0) begin
            bad++;
            $display("FAIL R1: in_sel=%0d color_sel=%0d expected 0 0", in_sel, color_sel);
        end

        cur_req = "R2";
        write_mode(0);
        for (int i = 0; i < 5; i++) run_line(4, 0);

        cur_req = "R3";
        write_mode(1);
        for (int i = 0; i < 3; i++) run_line(7, 0);

        cur_req = "R4";
        for (int c = 2; c < 6; c++) begin
            write_mode(c);
            run_line(3, 0);
            run_line(2, 0);
        end

        cur_req = "R5";
        write_mode(6);
        for (int i = 0; i < 4; i++) run_line(5, 0);

        cur_req = "R6";
        write_mode(7);
        for (int i = 0; i < 4; i++) run_line(9, 0);

        cur_req = "R8";
        write_mode(1);
        run_line(2, 1);
        run_line(4, 1);

        cur_req = "R7";
        // step strobe held across the line-start edge
        @(negedge clk);
        line_sync = 1'b1;
        tick(2);
        conv_done = 1'b1;
        tick(1);
        line_sync = 1'b0;
        tick(1);
        conv_done = 1'b0;
        tick(2);

        cur_req = "R9";
        write_mode(0);
        run_line(2, 0);
        run_line(2, 0);
        write_mode(0);
        run_line(2, 0);
        run_line(2, 0);
        // write pulse coincident with the line-start edge
        @(negedge clk);
        line_sync = 1'b1;
        tick(2);
        line_sync    = 1'b0;
        mode_written = 1'b1;
        tick(1);
        mode_written = 1'b0;
        tick(3);
        run_line(1, 0);

        cur_req = "R10";
        run_line(0, 0);
        mode_code    = 3'd7;
        mode_written = 1'b1;
        tick(1);
        mode_written = 1'b0;
        for (int i = 0; i < 4; i++) begin
            conv_done = 1'b1;
            tick(1);
            conv_done = 1'b0;
            tick(1);
        end
        run_line(5, 0);
        run_line(5, 0);

        tick(2);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule